// File: doc/BRIEF.md
# Inter-processor signal interrupt controller

This block is a small register-mapped controller through which a processor raises numbered signals toward other clients and collects the signals addressed to it. A signal is named by a 32-bit identifier. The upper half is a client number and the lower half is a signal number. Every operation uses one such identifier: raising, unmasking, masking and acknowledging a signal each take one word written to its own register. None of them takes a bitmap.

The receive side holds a table of entries. Each entry has a fixed identifier, a pending flag and an enable flag. An identifier written to the send register leaves the block as a one-cycle transmit pulse. It is also looped back into the table, where it sets the pending flag of the entry whose identifier matches. Software services the level interrupt in a loop. It reads the receive register, which returns the identifier of the lowest enabled pending entry. It then writes that identifier back to the clear register, and it stops when the read returns all ones. A client-wide clear drops every pending signal of one client in a single write.

Entry `i` carries client `BASE_CLIENT + i / SIG_PER_CLIENT` and signal `i % SIG_PER_CLIENT`. With the defaults (16 entries, base client 2, 4 signals per client), entries 0 to 3 are client 2, signals 0 to 3, and entries 12 to 15 are client 5, signals 0 to 3.

Top module: `sigirq_ctrl`

## Requirements
- R1: After reset every entry is disabled and not pending: the receive register (byte offset 0x10) reads 0xFFFFFFFF and `irq_out` is low.
- R2: A write of an identifier (client in bits 31:16, signal in bits 15:0) to the send register (offset 0x0C) sets the pending flag of the entry with that identifier. Once the entry is enabled, its identifier is returned by the receive register.
- R3: A write to the send register makes `tx_valid` high for exactly the following clock cycle, with `tx_id` equal to the written word. `tx_valid` is never high otherwise.
- R4: An identifier that matches no entry, when written to the send register, changes no pending flag.
- R5: A pending flag is set and held whether or not its entry is enabled. A disabled pending entry is not reported. A write of its identifier to the enable register (offset 0x14) makes it reportable, and that write changes no pending flag.
- R6: A write of an identifier to the disable register (offset 0x18) masks only that entry. Other enabled pending entries stay reported, and the masked entry's pending flag is kept.
- R7: A write of an identifier to the clear register (offset 0x1C) drops the pending flag of that entry only. Repeating read-then-clear drains every enabled pending entry and ends in 0xFFFFFFFF.
- R8: When several enabled entries are pending, the receive register returns the identifier of the lowest-index entry. It re-evaluates in the cycle after each clear.
- R9: A write to the client clear register (offset 0x38) drops the pending flag of every entry whose client equals bits 31:16 of the written word. Bits 15:0 are ignored, and other clients' entries are untouched.
- R10: `irq_out` is high exactly when at least one entry is both enabled and pending.
- R11: Reads of the write-only registers (0x0C, 0x14, 0x18, 0x1C, 0x38) and of any undefined offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Register write strobe, one write per cycle |
| bus_addr | input | ADDR_W (8) | Register byte offset |
| bus_wdata | input | 32 | Write data (an identifier) |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_out | output | 1 | Level summary interrupt, active high |
| tx_valid | output | 1 | One-cycle pulse for a raised signal |
| tx_id | output | 32 | Identifier of the raised signal |

## Verification
The main function is tried with several distinct patterns:
- A single signal raised while masked and later unmasked. This separates latching of the pending flag from reporting it.
- Three signals raised in non-index order. This shows that reporting follows entry index rather than arrival order, and that each clear moves to the next entry.
- Identifiers with a valid client but an out-of-range signal, and with an unknown client. These must leave the table untouched even with every entry enabled.
- Masking one of two pending signals, and clearing a whole client while another client is pending. These show that each operation reaches only the entries its identifier names.

// File: rtl/sigirq_pkg.sv
package sigirq_pkg;

  typedef logic [31:0] sig_id_t;

  localparam int OFS_SEND = 'h0C;
  localparam int OFS_RECV = 'h10;
  localparam int OFS_EN   = 'h14;
  localparam int OFS_DIS  = 'h18;
  localparam int OFS_CLR  = 'h1C;
  localparam int OFS_CCLR = 'h38;

  localparam sig_id_t NONE_ID = 32'hFFFF_FFFF;

  // Identifier of table entry idx: client in the upper half, signal in the lower half.
  function automatic sig_id_t entry_id(input int idx, input int base, input int spc);
    entry_id = {16'(base + idx / spc), 16'(idx % spc)};
  endfunction

endpackage

// File: rtl/sigirq_regif.sv
module sigirq_regif
  import sigirq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  sig_id_t           recv_id,
  output logic              wr_send,
  output logic              wr_en,
  output logic              wr_dis,
  output logic              wr_clr,
  output logic              wr_cclr,
  output sig_id_t           bus_rdata
);

  always_comb begin
    wr_send = bus_we && (bus_addr == ADDR_W'(OFS_SEND));
    wr_en   = bus_we && (bus_addr == ADDR_W'(OFS_EN));
    wr_dis  = bus_we && (bus_addr == ADDR_W'(OFS_DIS));
    wr_clr  = bus_we && (bus_addr == ADDR_W'(OFS_CLR));
    wr_cclr = bus_we && (bus_addr == ADDR_W'(OFS_CCLR));
  end

  // Only the receive register is readable; all else returns zero.
  always_comb begin
    if (bus_addr == ADDR_W'(OFS_RECV)) bus_rdata = recv_id;
    else                               bus_rdata = '0;
  end

endmodule

// File: rtl/sigirq_entry.sv
module sigirq_entry
  import sigirq_pkg::*;
#(
  parameter sig_id_t ENTRY_ID = 32'h0
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr_send,
  input  logic    wr_en,
  input  logic    wr_dis,
  input  logic    wr_clr,
  input  logic    wr_cclr,
  input  sig_id_t wdata,
  output logic    pend_o,
  output logic    en_o
);

  logic id_hit, client_hit;
  logic pend_q, pend_d, pend_ce;
  logic en_q, en_d, en_ce;

  always_comb begin
    id_hit     = (wdata == ENTRY_ID);
    client_hit = (wdata[31:16] == ENTRY_ID[31:16]);

    pend_ce = (wr_send && id_hit) || (wr_clr && id_hit) || (wr_cclr && client_hit);
    pend_d  = wr_send;

    en_ce = (wr_en || wr_dis) && id_hit;
    en_d  = wr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      if (pend_ce) pend_q <= pend_d;
      if (en_ce)   en_q   <= en_d;
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;

endmodule

// File: rtl/sigirq_prio.sv
module sigirq_prio #(
  parameter int N = 16
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);

  logic [N:0] taken;

  always_comb begin
    taken[0] = 1'b0;
    for (int i = 0; i < N; i++) begin
      grant[i]   = req[i] && !taken[i];
      taken[i+1] = taken[i] || req[i];
    end
  end

endmodule

// File: rtl/sigirq_ctrl.sv
module sigirq_ctrl
  import sigirq_pkg::*;
#(
  parameter int N_ENTRY        = 16,
  parameter int BASE_CLIENT    = 2,
  parameter int SIG_PER_CLIENT = 4,
  parameter int ADDR_W         = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_out,
  output logic              tx_valid,
  output logic [31:0]       tx_id
);

  localparam int N = N_ENTRY;

  // Reset synchronizer: asserts at once, releases on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic    wr_send, wr_en, wr_dis, wr_clr, wr_cclr;
  sig_id_t recv_id;
  logic [N-1:0] pend_vec, en_vec, grant;
  sig_id_t id_tab [N];

  sigirq_regif #(.ADDR_W(ADDR_W)) u_regif (
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .recv_id  (recv_id),
    .wr_send  (wr_send),
    .wr_en    (wr_en),
    .wr_dis   (wr_dis),
    .wr_clr   (wr_clr),
    .wr_cclr  (wr_cclr),
    .bus_rdata(bus_rdata)
  );

  for (genvar gi = 0; gi < N; gi++) begin : g_ent
    localparam sig_id_t EID = entry_id(gi, BASE_CLIENT, SIG_PER_CLIENT);
    assign id_tab[gi] = EID;
    sigirq_entry #(.ENTRY_ID(EID)) u_ent (
      .clk    (clk),
      .rst_n  (rst_n_int),
      .wr_send(wr_send),
      .wr_en  (wr_en),
      .wr_dis (wr_dis),
      .wr_clr (wr_clr),
      .wr_cclr(wr_cclr),
      .wdata  (bus_wdata),
      .pend_o (pend_vec[gi]),
      .en_o   (en_vec[gi])
    );
  end

  sigirq_prio #(.N(N)) u_prio (
    .req  (pend_vec & en_vec),
    .grant(grant)
  );

  always_comb begin
    sig_id_t acc;
    acc = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) acc = acc | id_tab[i];
    end
    recv_id = (grant == '0) ? NONE_ID : acc;
  end

  assign irq_out = |(pend_vec & en_vec);

  // Transmit pulse: next-state and register processes kept apart.
  logic    tx_valid_q, tx_valid_d;
  sig_id_t tx_id_q;

  always_comb tx_valid_d = wr_send;

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      tx_valid_q <= 1'b0;
      tx_id_q    <= '0;
    end else begin
      tx_valid_q <= tx_valid_d;
      if (wr_send) tx_id_q <= bus_wdata;
    end
  end

  assign tx_valid = tx_valid_q;
  assign tx_id    = tx_id_q;

endmodule

// File: rtl/sigirq_ctrl_chk.sv
module sigirq_ctrl_chk
  import sigirq_pkg::*;
#(
  parameter int N      = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              irq_out,
  input logic              tx_valid,
  input logic [31:0]       tx_id,
  input logic [N-1:0]      pend_vec,
  input logic [N-1:0]      en_vec,
  input logic [N-1:0]      grant,
  input logic [31:0]       recv_id
);

  logic w_send, w_en, w_dis, w_clr, w_cclr;
  assign w_send = bus_we && (bus_addr == ADDR_W'(OFS_SEND));
  assign w_en   = bus_we && (bus_addr == ADDR_W'(OFS_EN));
  assign w_dis  = bus_we && (bus_addr == ADDR_W'(OFS_DIS));
  assign w_clr  = bus_we && (bus_addr == ADDR_W'(OFS_CLR));
  assign w_cclr = bus_we && (bus_addr == ADDR_W'(OFS_CCLR));

  p_tx_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    w_send |=> (tx_valid && tx_id == $past(bus_wdata)));

  p_tx_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!w_send) |=> !tx_valid);

  p_enable_keeps_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    w_en |=> (pend_vec == $past(pend_vec)));

  p_disable_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    w_dis |=> ((pend_vec == $past(pend_vec)) && ($countones(en_vec ^ $past(en_vec)) <= 1)));

  p_clear_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (w_clr && bus_wdata == recv_id && recv_id != NONE_ID) |=> (recv_id != $past(recv_id)));

  p_grant_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_cclr_no_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    w_cclr |=> ((pend_vec & ~$past(pend_vec)) == '0));

  p_irq_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (recv_id != NONE_ID));

endmodule

bind sigirq_ctrl sigirq_ctrl_chk #(.N(N_ENTRY), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_int),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .irq_out  (irq_out),
  .tx_valid (tx_valid),
  .tx_id    (tx_id),
  .pend_vec (pend_vec),
  .en_vec   (en_vec),
  .grant    (grant),
  .recv_id  (recv_id)
);

// File: tb/sigirq_ctrl_tb.sv
module sigirq_ctrl_tb;

  localparam int ADDR_W = 8;
  localparam logic [7:0] A_SEND = 8'h0C, A_RECV = 8'h10, A_EN = 8'h14,
                         A_DIS = 8'h18, A_CLR = 8'h1C, A_CCLR = 8'h38;
  localparam logic [31:0] NONE = 32'hFFFF_FFFF;

  logic              clk;
  logic              rst_n;
  logic              bus_we;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0]       bus_wdata;
  logic [31:0]       bus_rdata;
  logic              irq_out;
  logic              tx_valid;
  logic [31:0]       tx_id;

  int n_chk;
  int n_fail;
  logic last_txv;
  logic [31:0] last_txid;

  sigirq_ctrl u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq_out  (irq_out),
    .tx_valid (tx_valid),
    .tx_id    (tx_id)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Identifier of entry i: client 2 + i/4, signal i%4.
  function automatic logic [31:0] eid(input int i);
    eid = {16'(2 + i / 4), 16'(i % 4)};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Write one register; returns at the next negedge, with state updated.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'h00; bus_wdata = '0;
    last_txv = tx_valid; last_txid = tx_id;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_RECV, v);
    check("R1", "recv after reset", v, NONE);
    check("R1", "irq after reset", {31'b0, irq_out}, 32'd0);
    check("R3", "no tx after reset", {31'b0, tx_valid}, 32'd0);
  endtask

  task automatic t_send_masked;
    logic [31:0] v;
    wr(A_SEND, eid(5));
    check("R3", "tx pulse", {31'b0, last_txv}, 32'd1);
    check("R3", "tx id", last_txid, eid(5));
    @(negedge clk);
    check("R3", "tx pulse ends", {31'b0, tx_valid}, 32'd0);
    rd(A_RECV, v);
    check("R5", "masked pending hidden", v, NONE);
    check("R10", "irq low while masked", {31'b0, irq_out}, 32'd0);
    wr(A_EN, eid(5));
    rd(A_RECV, v);
    check("R2", "enabled pending reported", v, eid(5));
    check("R10", "irq high", {31'b0, irq_out}, 32'd1);
    wr(A_CLR, eid(5));
    rd(A_RECV, v);
    check("R7", "cleared", v, NONE);
    check("R10", "irq low after clear", {31'b0, irq_out}, 32'd0);
  endtask

  task automatic t_unmatched;
    logic [31:0] v;
    for (int i = 0; i < 16; i++) wr(A_EN, eid(i));
    wr(A_SEND, 32'h0002_0004);
    wr(A_SEND, 32'h0009_0000);
    wr(A_SEND, 32'h0000_0001);
    rd(A_RECV, v);
    check("R4", "unmatched ids ignored", v, NONE);
    check("R4", "irq stays low", {31'b0, irq_out}, 32'd0);
  endtask

  task automatic t_priority;
    logic [31:0] v;
    wr(A_SEND, eid(9));
    wr(A_SEND, eid(3));
    wr(A_SEND, eid(14));
    rd(A_RECV, v);
    check("R8", "lowest index first", v, eid(3));
    wr(A_CLR, eid(3));
    rd(A_RECV, v);
    check("R8", "next after clear", v, eid(9));
    wr(A_CLR, eid(9));
    rd(A_RECV, v);
    check("R8", "last entry", v, eid(14));
    wr(A_CLR, eid(14));
    rd(A_RECV, v);
    check("R7", "drain ends in all ones", v, NONE);
  endtask

  task automatic t_disable;
    logic [31:0] v;
    wr(A_SEND, eid(2));
    wr(A_SEND, eid(7));
    wr(A_DIS, eid(2));
    rd(A_RECV, v);
    check("R6", "other entry still reported", v, eid(7));
    check("R10", "irq high with one left", {31'b0, irq_out}, 32'd1);
    wr(A_DIS, eid(7));
    rd(A_RECV, v);
    check("R6", "both masked", v, NONE);
    check("R10", "irq low when all masked", {31'b0, irq_out}, 32'd0);
    wr(A_EN, eid(2));
    rd(A_RECV, v);
    check("R5", "pending kept across mask", v, eid(2));
    wr(A_EN, eid(7));
    wr(A_CLR, eid(2));
    rd(A_RECV, v);
    check("R7", "clear only named entry", v, eid(7));
    wr(A_CLR, eid(7));
    rd(A_RECV, v);
    check("R7", "empty again", v, NONE);
  endtask

  task automatic t_client_clear;
    logic [31:0] v;
    wr(A_SEND, eid(4));
    wr(A_SEND, eid(5));
    wr(A_SEND, eid(6));
    wr(A_SEND, eid(12));
    rd(A_RECV, v);
    check("R8", "client 3 entry first", v, eid(4));
    wr(A_CCLR, 32'h0003_ABCD);
    rd(A_RECV, v);
    check("R9", "client 3 cleared, client 5 kept", v, eid(12));
    wr(A_CLR, eid(12));
    rd(A_RECV, v);
    check("R9", "nothing of client 3 left", v, NONE);
  endtask

  task automatic t_regread;
    logic [31:0] v;
    wr(A_SEND, eid(1));
    rd(A_SEND, v); check("R11", "send reads zero", v, 32'd0);
    rd(A_EN, v);   check("R11", "enable reads zero", v, 32'd0);
    rd(A_DIS, v);  check("R11", "disable reads zero", v, 32'd0);
    rd(A_CLR, v);  check("R11", "clear reads zero", v, 32'd0);
    rd(A_CCLR, v); check("R11", "client clear reads zero", v, 32'd0);
    rd(8'h00, v);  check("R11", "offset 0 reads zero", v, 32'd0);
    rd(8'h3C, v);  check("R11", "offset 3C reads zero", v, 32'd0);
    rd(A_RECV, v); check("R2", "recv still readable", v, eid(1));
  endtask

  initial begin
    n_chk = 0; n_fail = 0;
    bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_send_masked();
    t_unmatched();
    t_priority();
    t_disable();
    t_client_clear();
    t_regread();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule